// File: doc/BRIEF.md
# Seven-to-one DDR panel serializer

This block turns one 18-bit RGB pixel plus its horizontal sync, vertical sync and data-enable flags into the serial bit streams of a flat-panel differential link. There are three data lanes and a clock lane. In every pixel clock period each lane sends one 7-bit word. Each lane leaves the block as a bit pair, one bit for the rising half and one for the falling half of a fast clock. The pair feeds a double-data-rate output register that sits outside this block.

The fast clock runs at 3.5 times the pixel clock, and the two clocks are phase-locked. Two pixel words make 14 bits, and these go out in exactly seven fast cycles. A two-entry buffer in the pixel domain takes even pixels in one entry and odd pixels in the other. Once every seven fast cycles, at a phase when both entries are stable, the fast domain copies both entries into a 14-bit group register per lane. A seven-state phase counter then steps through that register two bits at a time. Because 7 is odd, the step at phase 3 straddles the boundary between the two words.

Top module: `panel_gearbox7`

## Requirements
- R1: While `rst` is high, each fast-clock edge sets the phase to 0 and clears every data lane's group. From the next edge on, every data lane outputs 0 on both halves and the clock lane outputs its phase-0 pair, 1 then 1.
- R2: After reset, the phase advances by one on each fast-clock edge and wraps from 6 to 0. The output pattern therefore repeats every seven fast cycles.
- R3: In phase p a lane outputs stream bit 2p on `*_rise` and bit 2p+1 on `*_fall`. Stream bits 0..6 are the even pixel's word and bits 7..13 are the odd pixel's word, each sent from word bit 6 down to word bit 0.
- R4: The word for data lane 0 (bit 6 down to bit 0) is green bit 0 followed by red bits 5..0.
- R5: The word for data lane 1 (bit 6 down to bit 0) is blue bits 1..0 followed by green bits 5..1.
- R6: The word for data lane 2 (bit 6 down to bit 0) is data-enable, vertical sync, horizontal sync, then blue bits 5..2.
- R7: The clock lane sends the word 1100011 in every pixel period. In phase 3 its pair is therefore the last bit of one word (1) followed by the first bit of the next (1).
- R8: Take the pixels sampled at the first two pixel-clock edges after reset. They appear on the lanes starting with the seventh fast edge after reset, which is six fast cycles after the first pixel was sampled. The two entries of each pair are copied only at the edge that leaves phase 6, and every later pair follows with the same latency.
- R9: Consecutive pixels go to alternate buffer entries. Pixel 2k supplies stream bits 0..6 of a group and pixel 2k+1 supplies bits 7..13, so the phase-3 pair joins the two pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serializer clock, 3.5x the pixel clock, phase-locked to it |
| clk_pix | input | 1 | Pixel clock |
| rst | input | 1 | Active-high synchronous reset, seen by both clocks |
| px_r | input | 6 | Red component |
| px_g | input | 6 | Green component |
| px_b | input | 6 | Blue component |
| px_hs | input | 1 | Horizontal sync |
| px_vs | input | 1 | Vertical sync |
| px_de | input | 1 | Data enable |
| data_rise | output | 3 | Rising-half bit of data lanes 2..0 |
| data_fall | output | 3 | Falling-half bit of data lanes 2..0 |
| clkl_rise | output | 1 | Rising-half bit of the clock lane |
| clkl_fall | output | 1 | Falling-half bit of the clock lane |

## Verification
The assertions assume that the two clocks are phase-locked in a 2:7 ratio. They also assume that reset is released so that the first active pixel edge coincides with the first active fast edge, which keeps buffer writes away from the phase-6 copy. The bench builds both clocks from one time base with coincident rising edges every 140 ns, and it releases reset 5 ns before such an edge. It changes pixel inputs only on falling pixel-clock edges. A reference model computes every lane pair from the requirements for all seven phases, and it runs over directed all-ones, all-zeros and alternating words followed by random pixels.

// File: rtl/panel_gearbox7.sv
module panel_gearbox7 #(
  parameter logic [6:0] CLK_WORD = 7'b1100011
) (
  input  logic       clk_fast,
  input  logic       clk_pix,
  input  logic       rst,
  input  logic [5:0] px_r,
  input  logic [5:0] px_g,
  input  logic [5:0] px_b,
  input  logic       px_hs,
  input  logic       px_vs,
  input  logic       px_de,
  output logic [2:0] data_rise,
  output logic [2:0] data_fall,
  output logic       clkl_rise,
  output logic       clkl_fall
);
  localparam int WORD_W = 7;
  localparam int LANES = 3;
  localparam int GRP_W = 2 * WORD_W;
  localparam int ENT_W = LANES * WORD_W;
  localparam logic [2:0] PH_LAST = 3'(WORD_W - 1);

  logic [ENT_W-1:0] pix_word;
  logic [ENT_W-1:0] ent [2];
  logic             wsel;
  logic [2:0]       ph;
  logic [GRP_W-1:0] grp [LANES];
  logic [3:0]       shamt;

  assign pix_word = {px_de, px_vs, px_hs, px_b[5:2],
                     px_b[1:0], px_g[5:1],
                     px_g[0], px_r};

  always_ff @(posedge clk_pix) begin
    if (rst) begin
      wsel <= 1'b0;
    end else begin
      ent[wsel] <= pix_word;
      wsel      <= ~wsel;
    end
  end

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      ph <= '0;
      for (int l = 0; l < LANES; l++) grp[l] <= '0;
    end else begin
      ph <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
      if (ph == PH_LAST)
        for (int l = 0; l < LANES; l++)
          grp[l] <= {ent[0][l*WORD_W +: WORD_W], ent[1][l*WORD_W +: WORD_W]};
    end
  end

  assign shamt = {ph, 1'b0};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [GRP_W-1:0] sh;
    assign sh = grp[l] << shamt;
    assign data_rise[l] = sh[GRP_W-1];
    assign data_fall[l] = sh[GRP_W-2];
  end

  logic [GRP_W-1:0] clk_sh;
  assign clk_sh    = {CLK_WORD, CLK_WORD} << shamt;
  assign clkl_rise = clk_sh[GRP_W-1];
  assign clkl_fall = clk_sh[GRP_W-2];

  p_phase_range_r2: assert property (@(posedge clk_fast) disable iff (rst)
    ph <= PH_LAST);
  p_phase_wrap_r2: assert property (@(posedge clk_fast) disable iff (rst)
    ph == PH_LAST |=> ph == 3'd0);
  p_reset_clear_r1: assert property (@(posedge clk_fast)
    rst |=> (data_rise == 3'b000 && data_fall == 3'b000));
  p_hold_between_loads_r8: assert property (@(posedge clk_fast) disable iff (rst)
    ph != PH_LAST |=> $stable(grp[0]) && $stable(grp[1]) && $stable(grp[2]));
  p_clk_boundary_r7: assert property (@(posedge clk_fast) disable iff (rst)
    ph == 3'd3 |-> (clkl_rise == CLK_WORD[0] && clkl_fall == CLK_WORD[WORD_W-1]));
  p_entry_alternate_r9: assert property (@(posedge clk_pix) disable iff (rst)
    1'b1 |=> wsel != $past(wsel));
endmodule

// File: tb/panel_gearbox7_tb.sv
module panel_gearbox7_tb;
  localparam int NPIX = 200;
  localparam int NCYC = 7 * (NPIX / 2) + 6;
  localparam logic [6:0] CLKW = 7'b1100011;

  logic clk_fast = 1'b0, clk_pix = 1'b0, rst;
  logic [5:0] px_r, px_g, px_b;
  logic px_hs, px_vs, px_de;
  logic [2:0] data_rise, data_fall;
  logic clkl_rise, clkl_fall;
  logic [20:0] pix [NPIX];
  int tests = 0, fails = 0;
  bit done = 0;

  panel_gearbox7 u_dut (
    .clk_fast(clk_fast), .clk_pix(clk_pix), .rst(rst),
    .px_r(px_r), .px_g(px_g), .px_b(px_b),
    .px_hs(px_hs), .px_vs(px_vs), .px_de(px_de),
    .data_rise(data_rise), .data_fall(data_fall),
    .clkl_rise(clkl_rise), .clkl_fall(clkl_fall));

  always #10 clk_fast = ~clk_fast;
  initial begin
    #10;
    forever begin clk_pix = 1'b1; #35; clk_pix = 1'b0; #35; end
  end

  task automatic apply(input int k);
    {px_de, px_vs, px_hs, px_b, px_g, px_r} = pix[k];
  endtask

  function automatic logic [6:0] lane_word(input int lane, input logic [20:0] p);
    logic [5:0] r, g, b;
    r = p[5:0]; g = p[11:6]; b = p[17:12];
    case (lane)
      0: return {g[0], r};
      1: return {b[1:0], g[5:1]};
      2: return {p[20], p[19], p[18], b[5:2]};
      default: return CLKW;
    endcase
  endfunction

  function automatic logic stream_bit(input int lane, input int g, input int idx);
    logic [6:0] w;
    if (idx < 7) begin w = lane_word(lane, pix[2*g]); return w[6-idx]; end
    w = lane_word(lane, pix[2*g+1]);
    return w[13-idx];
  endfunction

  task automatic check(input string tag, input int n, input int lane,
                       input logic [1:0] got, input logic [1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d lane %0d got %b expected %b", tag, n, lane, got, exp);
    end
  endtask

  task automatic check_cycle(input int n);
    int p, g;
    logic [1:0] exp, got;
    string tag;
    p = n % 7;
    g = (n - 7) / 7;
    for (int lane = 0; lane < 3; lane++) begin
      if (n < 7) exp = 2'b00;
      else exp = {stream_bit(lane, g, 2*p), stream_bit(lane, g, 2*p+1)};
      got = {data_rise[lane], data_fall[lane]};
      if (n == 7) tag = "R8";
      else if (p == 3) tag = "R9";
      else if (p == 0 && lane == 0) tag = "R3";
      else tag = (lane == 0) ? "R4" : (lane == 1) ? "R5" : "R6";
      check(tag, n, lane, got, exp);
    end
    exp = {CLKW[6 - ((2*p) % 7)], CLKW[6 - ((2*p+1) % 7)]};
    check((p == 3) ? "R7" : "R2", n, 3, {clkl_rise, clkl_fall}, exp);
  endtask

  initial begin
    pix[0] = 21'h1FFFFF;
    pix[1] = 21'h000000;
    pix[2] = 21'h155555;
    pix[3] = 21'h0AAAAA;
    for (int k = 4; k < NPIX; k++) pix[k] = 21'($urandom);
    rst = 1'b1;
    apply(0);
    #100;
    check("R1", 0, 0, {data_rise[0], data_fall[0]}, 2'b00);
    check("R1", 0, 1, {data_rise[1], data_fall[1]}, 2'b00);
    check("R1", 0, 2, {data_rise[2], data_fall[2]}, 2'b00);
    check("R1", 0, 3, {clkl_rise, clkl_fall}, 2'b11);
    #45 rst = 1'b0;
    fork
      begin
        for (int k = 1; k < NPIX; k++) begin @(negedge clk_pix); apply(k); end
      end
      begin
        for (int n = 1; n <= NCYC; n++) begin
          @(posedge clk_fast);
          @(negedge clk_fast);
          check_cycle(n);
        end
      end
    join
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule